// File: doc/BRIEF.md
# Host Bus Configuration Capture Unit

This block sits between a host processor bus and the register file of a peripheral controller. After a hardware reset it has no configuration. The first write that the host makes with the chip select active is taken as the configuration word, whatever address is on the bus. At that moment the block also records the level of a handshake-select pin. That recorded level fixes, until the next reset, how the block drives its active-low wait/ready output.

Once configured, the block works out the register address and the upper/lower byte flag for each host access. It uses one of three decode modes:

- **Multiplexed mode.** The address is latched from the low bus bits when the address strobe rises.
- **Separate-address mode, strobe-timed.** The address is taken from the upper bus byte on the falling edge of a data, read or write strobe.
- **Separate-address mode, address-strobe-timed.** The address is taken from the upper bus byte on the rising edge of the address strobe. This mode applies only if address-strobe activity was seen before the configuration write.

All inputs pass through a synchronizer of SYNC_STAGES flops before any edge is detected. All outputs are registered.

Top module: `hbus_cfg_capture`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cfg_valid` is 0, `reg_addr` is 0, `byte_hi` is 0 and `wait_rdy_n` is 1.
- R2: The first falling edge of `wr_n` seen with `cs_n` low after reset loads `ad` into the 16-bit configuration word and sets `cfg_valid`. Any address may be on the bus at that time. Later writes never reload the configuration word, and `cfg_valid` stays 1 until reset.
- R3: While `cfg_valid` is 0, `reg_addr` and `byte_hi` stay 0 whatever strobes arrive.
- R4: The level of `hs_sel` is captured by the configuration write. Later changes of `hs_sel` do not change the handshake behaviour.
- R5: Acknowledge mode applies when the captured `hs_sel` was 0. `wait_rdy_n` is driven low while an interrupt acknowledge (`iack_n` low) is active. It is also driven low during a register access, meaning `cs_n` low with any of `ds_n`, `rd_n` or `wr_n` low. Otherwise it is high. It follows the pins SYNC_STAGES+1 clock edges later.
- R6: Wait mode applies when the captured `hs_sel` was 1. `wait_rdy_n` ignores register accesses. During an interrupt acknowledge it is low for the first WAIT_CYCLES clock edges and then high until `iack_n` is released.
- R7: In multiplexed mode, each rising edge of `as_n` loads `reg_addr` from `ad[ADDR_W:1]` and `byte_hi` from `ad[0]`.
- R8: Separate-address mode is selected only when configuration bit 15 is 1 and bit 14 is 0. Any other combination gives multiplexed mode.
- R9: In separate-address mode with no address-strobe activity seen, a falling edge of `ds_n`, `rd_n` or `wr_n` with `cs_n` low loads `reg_addr` from `ad[13:9]` and `byte_hi` from `ad[8]`. `as_n` edges are ignored in this mode.
- R10: In separate-address mode with address-strobe activity seen, a rising edge of `as_n` loads `reg_addr` from `ad[13:9]` and `byte_hi` from `ad[8]`. Data, read and write strobe edges do not change the decode in this mode.
- R11: Address-strobe activity is a sticky flag. It is set by a falling edge of `as_n` after reset and before the configuration write, and it is frozen once `cfg_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| iack_n | input | 1 | Interrupt acknowledge cycle, active low |
| hs_sel | input | 1 | Handshake select level, captured at configuration |
| ad | input | DATA_W | Host address/data bus |
| reg_addr | output | ADDR_W | Decoded register address |
| byte_hi | output | 1 | Upper (1) or lower (0) byte indication |
| cfg_valid | output | 1 | Configuration word has been written |
| wait_rdy_n | output | 1 | Wait or acknowledge output, active low |

## Verification
The bench issues a read and an address-strobe pulse before configuration. A design that decodes early would move `reg_addr` off zero on these. It then writes a second time after configuration and toggles `hs_sel`. A design that reloads the configuration word would switch decode mode, and one that samples the pin live would flip the handshake polarity. Each of the three decode modes is also hit with the strobe that belongs to another mode. An address-strobe pulse before configuration must switch separate-address decode to address-strobe timing, while one after configuration must not. In wait mode the bench counts the exact edges of the low window, so an off-by-one counter or a missing release is caught.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // positions of the synchronized strobe bits
  localparam int S_CS     = 0;
  localparam int S_AS     = 1;
  localparam int S_DS     = 2;
  localparam int S_RD     = 3;
  localparam int S_WR     = 4;
  localparam int S_IACK   = 5;
  localparam int N_STROBE = 6;

  // configuration word fields whose position is decoded here
  localparam int CFG_SEP_BIT  = 15;
  localparam int CFG_WIDE_BIT = 14;

  typedef enum logic [1:0] {
    DEC_MUX        = 2'd0,
    DEC_SEP_STROBE = 2'd1,
    DEC_SEP_AS     = 2'd2
  } dec_mode_e;
endpackage

// File: rtl/hbus_in_sync.sv
module hbus_in_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      prev <= RST_VAL;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) pipe[i] <= pipe[i-1];
      pipe[0] <= din;
      prev    <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign fall = prev & ~lvl;
  assign rise = ~prev & lvl;

  a_r1_no_edge_in_reset: assert property (@(posedge clk) rst |=> (fall == '0 && rise == '0));
endmodule

// File: rtl/hbus_cfg_ctrl.sv
module hbus_cfg_ctrl
  import hbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              wr_fall,
  input  logic              as_fall,
  input  logic              hs_sel_lvl,
  input  logic [DATA_W-1:0] bus,
  output logic              cfg_valid,
  output logic              wait_mode,
  output dec_mode_e         dec_mode
);
  logic [DATA_W-1:0] cfg_q;
  logic              as_seen;
  logic              sep_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cfg_valid <= 1'b0;
      wait_mode <= 1'b0;
      as_seen   <= 1'b0;
    end else if (!cfg_valid) begin
      if (as_fall) as_seen <= 1'b1;
      if (cs_act && wr_fall) begin
        cfg_q     <= bus;
        wait_mode <= hs_sel_lvl;
        cfg_valid <= 1'b1;
      end
    end
  end

  assign sep_en = cfg_q[CFG_SEP_BIT] & ~cfg_q[CFG_WIDE_BIT];

  always_comb begin
    if (!sep_en)      dec_mode = DEC_MUX;
    else if (as_seen) dec_mode = DEC_SEP_AS;
    else              dec_mode = DEC_SEP_STROBE;
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!cfg_valid && !as_seen && cfg_q == '0));
  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (rst) cfg_valid |=> cfg_valid);
  a_r2_word_frozen:  assert property (@(posedge clk) disable iff (rst) cfg_valid |=> $stable(cfg_q));
  a_r4_mode_frozen:  assert property (@(posedge clk) disable iff (rst) cfg_valid |=> $stable(wait_mode));
  a_r11_seen_frozen: assert property (@(posedge clk) disable iff (rst) cfg_valid |=> $stable(as_seen));
  a_r11_seen_sticky: assert property (@(posedge clk) disable iff (rst) as_seen |=> as_seen);
endmodule

// File: rtl/hbus_addr_dec.sv
module hbus_addr_dec
  import hbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  input  dec_mode_e         dec_mode,
  input  logic              cs_act,
  input  logic              as_rise,
  input  logic              dstrb_fall,
  input  logic [DATA_W-1:0] bus,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              byte_hi
);
  localparam int SEP_LSB = DATA_W / 2;
  localparam int SEP_MSB = SEP_LSB + ADDR_W;

  logic              take_low;
  logic              take_high;
  logic [ADDR_W-1:0] low_addr;
  logic [ADDR_W-1:0] high_addr;

  assign low_addr  = bus[ADDR_W:1];
  assign high_addr = bus[SEP_MSB:SEP_LSB+1];

  always_comb begin
    take_low  = 1'b0;
    take_high = 1'b0;
    if (cfg_valid) begin
      unique case (dec_mode)
        DEC_MUX:        take_low  = as_rise;
        DEC_SEP_AS:     take_high = as_rise;
        DEC_SEP_STROBE: take_high = cs_act & dstrb_fall;
        default:        ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr <= '0;
      byte_hi  <= 1'b0;
    end else if (take_low) begin
      reg_addr <= low_addr;
      byte_hi  <= bus[0];
    end else if (take_high) begin
      reg_addr <= high_addr;
      byte_hi  <= bus[SEP_LSB];
    end
  end

  a_r3_no_early_decode: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |-> (reg_addr == '0 && !byte_hi));
  a_r7_mux_latch: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && dec_mode == DEC_MUX && as_rise) |=> reg_addr == $past(bus[ADDR_W:1]));
  a_r10_strobes_ignored: assert property (@(posedge clk) disable iff (rst)
    (dec_mode == DEC_SEP_AS && !as_rise) |=> $stable(reg_addr));
  a_r9_as_ignored: assert property (@(posedge clk) disable iff (rst)
    (dec_mode == DEC_SEP_STROBE && !dstrb_fall) |=> $stable(reg_addr));
endmodule

// File: rtl/hbus_handshake.sv
module hbus_handshake #(
  parameter int WAIT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_valid,
  input  logic wait_mode,
  input  logic reg_acc,
  input  logic iack,
  output logic wait_rdy_n
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 2);

  logic wait_hold;

  generate
    if (WAIT_CYCLES > 0) begin : g_wait_cnt
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !iack) cnt <= '0;
        else if (cnt < CNT_W'(WAIT_CYCLES)) cnt <= cnt + 1'b1;
      end
      assign wait_hold = iack && (cnt < CNT_W'(WAIT_CYCLES));
      a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WAIT_CYCLES));
    end else begin : g_no_wait
      assign wait_hold = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_rdy_n <= 1'b1;
    end else if (!cfg_valid) begin
      wait_rdy_n <= 1'b1;
    end else if (wait_mode) begin
      wait_rdy_n <= ~wait_hold;
    end else begin
      wait_rdy_n <= ~(reg_acc | iack);
    end
  end

  a_r6_access_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && wait_mode && !iack) |=> wait_rdy_n);
  a_r5_ack_drives: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && !wait_mode && (reg_acc || iack)) |=> !wait_rdy_n);
  a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |=> wait_rdy_n);
endmodule

// File: rtl/hbus_cfg_capture.sv
module hbus_cfg_capture
  import hbus_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              as_n,
  input  logic              ds_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              iack_n,
  input  logic              hs_sel,
  input  logic [DATA_W-1:0] ad,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              byte_hi,
  output logic              cfg_valid,
  output logic              wait_rdy_n
);
  localparam int BUS_W = DATA_W + 1;

  logic [N_STROBE-1:0] strb_raw, strb_lvl, strb_asrt, strb_deas;
  logic [BUS_W-1:0]    bus_raw, bus_lvl, bus_fall_nc, bus_rise_nc;
  logic [DATA_W-1:0]   bus;
  logic                hs_sel_lvl;
  logic                cs_act, reg_acc, iack, dstrb_fall, wait_mode;
  dec_mode_e           dec_mode;

  always_comb begin
    strb_raw         = '1;
    strb_raw[S_CS]   = cs_n;
    strb_raw[S_AS]   = as_n;
    strb_raw[S_DS]   = ds_n;
    strb_raw[S_RD]   = rd_n;
    strb_raw[S_WR]   = wr_n;
    strb_raw[S_IACK] = iack_n;
  end

  assign bus_raw = {hs_sel, ad};

  // active-low strobes: a falling level is an assertion
  hbus_in_sync #(.W(N_STROBE), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_strb_sync (
    .clk(clk), .rst(rst), .din(strb_raw),
    .lvl(strb_lvl), .fall(strb_asrt), .rise(strb_deas)
  );

  hbus_in_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst(rst), .din(bus_raw),
    .lvl(bus_lvl), .fall(bus_fall_nc), .rise(bus_rise_nc)
  );

  assign bus        = bus_lvl[DATA_W-1:0];
  assign hs_sel_lvl = bus_lvl[DATA_W];
  assign cs_act     = ~strb_lvl[S_CS];
  assign iack       = ~strb_lvl[S_IACK];
  assign reg_acc    = cs_act & (~strb_lvl[S_DS] | ~strb_lvl[S_RD] | ~strb_lvl[S_WR]);
  assign dstrb_fall = strb_asrt[S_DS] | strb_asrt[S_RD] | strb_asrt[S_WR];

  hbus_cfg_ctrl #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .cs_act(cs_act), .wr_fall(strb_asrt[S_WR]),
    .as_fall(strb_asrt[S_AS]), .hs_sel_lvl(hs_sel_lvl), .bus(bus),
    .cfg_valid(cfg_valid), .wait_mode(wait_mode), .dec_mode(dec_mode)
  );

  hbus_addr_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .dec_mode(dec_mode),
    .cs_act(cs_act), .as_rise(strb_deas[S_AS]), .dstrb_fall(dstrb_fall),
    .bus(bus), .reg_addr(reg_addr), .byte_hi(byte_hi)
  );

  hbus_handshake #(.WAIT_CYCLES(WAIT_CYCLES)) u_hs (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .wait_mode(wait_mode),
    .reg_acc(reg_acc), .iack(iack), .wait_rdy_n(wait_rdy_n)
  );
endmodule

// File: tb/hbus_cfg_capture_bench.sv
module hbus_cfg_capture_bench;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;
  localparam int WAITC  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, iack_n = 1'b1;
  logic hs_sel = 1'b0;
  logic [DATA_W-1:0] ad = '0;
  logic [ADDR_W-1:0] reg_addr;
  logic byte_hi, cfg_valid, wait_rdy_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hbus_cfg_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2), .WAIT_CYCLES(WAITC))
  u_hbus_cfg_capture (
    .clk(clk), .rst(rst), .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n), .rd_n(rd_n),
    .wr_n(wr_n), .iack_n(iack_n), .hs_sel(hs_sel), .ad(ad),
    .reg_addr(reg_addr), .byte_hi(byte_hi), .cfg_valid(cfg_valid), .wait_rdy_n(wait_rdy_n)
  );

  typedef struct packed {
    logic              sep;
    logic [DATA_W-1:0] bus;
    logic [ADDR_W-1:0] addr;
    logic              hi;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 16'h003F, 5'd31, 1'b1},
    '{1'b0, 16'h0014, 5'd10, 1'b0},
    '{1'b0, 16'hFF02, 5'd1,  1'b0},
    '{1'b0, 16'h0007, 5'd3,  1'b1},
    '{1'b1, 16'h3F00, 5'd31, 1'b1},
    '{1'b1, 16'h2A55, 5'd21, 1'b0},
    '{1'b1, 16'h0300, 5'd1,  1'b1},
    '{1'b1, 16'hC4FF, 5'd2,  1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    iack_n = 1'b1; ad = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic cfg_write(input logic [DATA_W-1:0] v);
    ad = v; cs_n = 1'b0; tick(3);
    wr_n = 1'b0; tick(4);
    wr_n = 1'b1; cs_n = 1'b1; tick(4);
  endtask

  task automatic as_pulse(input logic [DATA_W-1:0] v);
    ad = v; as_n = 1'b0; tick(3);
    as_n = 1'b1; tick(4);
  endtask

  // kind: 0 data strobe, 1 read strobe, 2 write strobe
  task automatic access(input int kind, input logic [DATA_W-1:0] v);
    ad = v; cs_n = 1'b0; tick(3);
    if (kind == 0) ds_n = 1'b0; else if (kind == 1) rd_n = 1'b0; else wr_n = 1'b0;
    tick(4);
    ds_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1; tick(4);
  endtask

  task automatic dec_chk(input string req, input int a, input int h);
    chk(req, int'(reg_addr), a);
    chk(req, int'(byte_hi), h);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(2);
    chk("R1 cfg_valid", int'(cfg_valid), 0);
    dec_chk("R1 decode", 0, 0);
    chk("R1 wait_rdy_n", int'(wait_rdy_n), 1);
    rst = 1'b0; tick(1);
    chk("R1 after release", int'(cfg_valid), 0);

    // Scenario A: multiplexed mode, acknowledge handshake
    hs_sel = 1'b0;
    access(1, 16'h3F00);
    dec_chk("R3 read before config", 0, 0);
    chk("R3 no ack before config", int'(wait_rdy_n), 1);
    as_pulse(16'h003F);
    dec_chk("R3 as before config", 0, 0);
    chk("R3 cfg_valid low", int'(cfg_valid), 0);
    cfg_write(16'h0000);
    chk("R2 cfg_valid set", int'(cfg_valid), 1);
    for (int i = 0; i < 8; i++) begin
      if (!VEC[i].sep) begin
        as_pulse(VEC[i].bus);
        dec_chk("R7 mux vector", int'(VEC[i].addr), int'(VEC[i].hi));
      end
    end
    access(1, 16'h3F00);
    dec_chk("R7 strobe ignored in mux", 3, 1);
    // R5 acknowledge timing
    cs_n = 1'b0; rd_n = 1'b0; tick(2);
    chk("R5 latency not yet", int'(wait_rdy_n), 1);
    tick(1);
    chk("R5 ack on access", int'(wait_rdy_n), 0);
    cs_n = 1'b1; rd_n = 1'b1; tick(4);
    chk("R5 released", int'(wait_rdy_n), 1);
    hs_sel = 1'b1; tick(4);
    iack_n = 1'b0; tick(8);
    chk("R4 R5 ack on iack after pin change", int'(wait_rdy_n), 0);
    iack_n = 1'b1; tick(4);
    // R2 second write must not reload (0x8000 would select separate mode)
    cfg_write(16'h8000);
    as_pulse(16'h0014);
    dec_chk("R2 second write ignored", 10, 0);

    // Scenario B: separate mode, strobe timed, wait handshake
    hs_sel = 1'b1;
    do_reset();
    cfg_write(16'h8000);
    chk("R2 cfg_valid B", int'(cfg_valid), 1);
    for (int i = 0; i < 8; i++) begin
      if (VEC[i].sep) begin
        access(i % 3, VEC[i].bus);
        dec_chk("R9 sep strobe vector", int'(VEC[i].addr), int'(VEC[i].hi));
      end
    end
    as_pulse(16'h3F00);
    dec_chk("R9 as ignored", 2, 0);
    access(0, 16'h2A55);
    dec_chk("R11 as after config not sticky", 21, 0);
    cs_n = 1'b0; rd_n = 1'b0; tick(6);
    chk("R6 no drive on access", int'(wait_rdy_n), 1);
    cs_n = 1'b1; rd_n = 1'b1; tick(4);
    hs_sel = 1'b0;
    iack_n = 1'b0; tick(2);
    chk("R6 wait latency", int'(wait_rdy_n), 1);
    tick(1);
    chk("R6 R4 wait first edge", int'(wait_rdy_n), 0);
    tick(2);
    chk("R6 wait last edge", int'(wait_rdy_n), 0);
    tick(1);
    chk("R6 wait released", int'(wait_rdy_n), 1);
    tick(3);
    chk("R6 stays released", int'(wait_rdy_n), 1);
    iack_n = 1'b1; tick(4);

    // Scenario C: separate mode, address-strobe timed
    do_reset();
    as_pulse(16'h0000);
    dec_chk("R11 as before config no decode", 0, 0);
    cfg_write(16'h8000);
    as_pulse(16'h2A55);
    dec_chk("R10 as rise decode", 21, 0);
    access(1, 16'h3F00);
    dec_chk("R10 read strobe ignored", 21, 0);
    as_pulse(16'h0300);
    dec_chk("R10 second as", 1, 1);

    // Scenario D: bit 15 with bit 14 set stays multiplexed
    do_reset();
    cfg_write(16'hC000);
    as_pulse(16'h0007);
    dec_chk("R8 wide bit forces mux", 3, 1);
    access(1, 16'h3F00);
    dec_chk("R8 strobe ignored", 3, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule